// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port synchronous static memory whose inputs and outputs are all registered. Each clock edge can carry a read, a write or an idle slot, in any order, with no dead cycle between them. The host drives one address/control bus. It writes through `din` and reads through `dout`, and `dout_oe` tells it in which cycles the memory owns the shared data wires. Write data is taken two edges after the write command. This is the same slot in which read data for a command at that edge appears, so the data wires never need a turnaround gap.

A burst is started by a normal command (a load). Each later edge with `adv` high steps the low two address bits inside an aligned four-word group, in linear or interleaved order. `clk_en` low freezes every register. `sleep` turns new commands into idle slots and lets the pipeline drain.

Top module: `zt_sram`

## Requirements
- R1: A read issued at enabled edge N produces `dout_oe`=1 and the read word on `dout` right after enabled edge N+1. Both stay until enabled edge N+2.
- R2: A write issued at enabled edge N takes `din` at enabled edge N+2. It updates only lanes whose `lane_we` bit was 1 when the command was issued. Lane i is bits 9i+8 to 9i.
- R3: Reads and writes may follow each other on every enabled edge with no idle edge between them, and each returns or stores the correct data.
- R4: If a read is issued on the enabled edge right after a write to the same address, it returns the write's `din` in the enabled lanes and the older memory content in the others.
- R5: `dout_oe` is 1 only in read data slots. It is 0 in write slots and in idle slots.
- R6: An edge with `clk_en`=0 is ignored. Pipeline, burst state, memory, `dout` and `dout_oe` all hold, and `din` at that edge is not taken.
- R7: With `adv`=1 and `lin_mode`=1 at the edge, the k-th advance after a load at address A uses address {A[5:2], (A[1:0]+k) mod 4}. It keeps the load's read/write type and uses the `lane_we` present at that edge.
- R8: With `adv`=1 and `lin_mode`=0, the k-th advance uses {A[5:2], A[1:0] XOR k}.
- R9: `adv`=1 after reset or after a deselect is an idle slot and changes no memory.
- R10: A deselect (`sel`=0, `adv`=0) is an idle slot. Writes already issued still complete in order with `din` at their own data slot.
- R11: While `sleep`=1 every command is an idle slot and no memory changes, but writes already issued still complete.
- R12: While `rst_n` is low the pipeline is empty and `dout_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | 1 = edge takes effect, 0 = whole block holds |
| sel | input | 1 | 1 = load a new command at `addr` |
| wr | input | 1 | Load type: 1 = write, 0 = read |
| adv | input | 1 | 1 = advance the current burst (overrides `sel`) |
| lin_mode | input | 1 | Burst order: 1 = linear, 0 = interleaved |
| lane_we | input | LANES (4) | Per-lane write enables for this edge's write |
| addr | input | AW (6) | Load address |
| sleep | input | 1 | 1 = accept no new commands |
| din | input | LANES*LANE_W (36) | Write data, taken in the write's data slot |
| dout | output | LANES*LANE_W (36) | Registered read data |
| dout_oe | output | 1 | 1 = memory drives the data wires this cycle |

## Verification
The hardest case to reach is a read that lands one edge behind a partial-lane write to the same address. In that case the result merges live `din` with stored data. If `clk_en` pauses fall in the middle, the pair must also stay aligned. Random traffic is confined to sixteen addresses with random lane masks, random enable gaps and random burst steps, so these collisions happen often. A directed partial-lane collision and a paused back-to-back stream make sure the case is covered on every run. A bench-side memory model and burst counter give the expected word for every read slot.

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int AW     = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en,
  input  logic                    sel,
  input  logic                    wr,
  input  logic                    adv,
  input  logic                    lin_mode,
  input  logic [LANES-1:0]        lane_we,
  input  logic [AW-1:0]           addr,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_oe
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic          b_act, b_wr;
  logic [AW-1:0] b_base;
  logic [1:0]    b_cnt;

  logic             s1_v, s1_wr, s2_v, s2_wr;
  logic [AW-1:0]    s1_addr, s2_addr;
  logic [LANES-1:0] s1_be, s2_be;
  logic [DW-1:0]    rd_data;

  wire [1:0] nxt_cnt  = b_cnt + 2'd1;
  wire [1:0] burst_lo = lin_mode ? (b_base[1:0] + nxt_cnt) : (b_base[1:0] ^ nxt_cnt);
  wire       load     = sel & ~adv & ~sleep;
  wire       step     = adv & b_act & ~sleep;
  wire       desel    = ~sel & ~adv & ~sleep;
  wire          op_wr   = load ? wr : b_wr;
  wire [AW-1:0] op_addr = load ? addr : {b_base[AW-1:2], burst_lo};
  wire          s1_rd   = s1_v & ~s1_wr;
  wire          hit     = s2_v & s2_wr & (s2_addr == s1_addr);

  always_comb begin
    rd_data = mem[s1_addr];
    for (int i = 0; i < LANES; i++)
      if (hit && s2_be[i]) rd_data[i*LANE_W +: LANE_W] = din[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_act   <= 1'b0;
      b_wr    <= 1'b0;
      b_base  <= '0;
      b_cnt   <= '0;
      s1_v    <= 1'b0;
      s1_wr   <= 1'b0;
      s1_addr <= '0;
      s1_be   <= '0;
      s2_v    <= 1'b0;
      s2_wr   <= 1'b0;
      s2_addr <= '0;
      s2_be   <= '0;
      dout    <= '0;
      dout_oe <= 1'b0;
    end else if (clk_en) begin
      if (load) begin
        b_act  <= 1'b1;
        b_wr   <= wr;
        b_base <= addr;
        b_cnt  <= '0;
      end else if (step) begin
        b_cnt <= nxt_cnt;
      end else if (desel) begin
        b_act <= 1'b0;
      end
      s1_v    <= load | step;
      s1_wr   <= op_wr;
      s1_addr <= op_addr;
      s1_be   <= lane_we;
      s2_v    <= s1_v;
      s2_wr   <= s1_wr;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
      dout_oe <= s1_rd;
      if (s1_rd) dout <= rd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (clk_en && s2_v && s2_wr)
      for (int i = 0; i < LANES; i++)
        if (s2_be[i]) mem[s2_addr][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/zt_sram_chk.sv
`timescale 1ns/1ps
module zt_sram_chk #(
  parameter int LANES = 4,
  parameter int DW    = 36,
  parameter int AW    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_en,
  input logic             sleep,
  input logic [DW-1:0]    din,
  input logic [DW-1:0]    dout,
  input logic             dout_oe,
  input logic             s1_v,
  input logic             s1_wr,
  input logic [AW-1:0]    s1_addr,
  input logic             s2_v,
  input logic             s2_wr,
  input logic [AW-1:0]    s2_addr,
  input logic [LANES-1:0] s2_be
);
  // R12
  oe_reset_chk: assert property (@(posedge clk) !rst_n |=> !dout_oe);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(dout) && $stable(dout_oe));

  // R1
  read_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && s1_v && !s1_wr) |=> dout_oe);

  // R5
  quiet_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !(s1_v && !s1_wr)) |=> !dout_oe);

  // R4
  forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && s1_v && !s1_wr && s2_v && s2_wr && s1_addr == s2_addr && (&s2_be))
      |=> dout == $past(din));

  // R11
  sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && sleep) |=> !s1_v);
endmodule

bind zt_sram zt_sram_chk #(.LANES(LANES), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sleep(sleep), .din(din),
  .dout(dout), .dout_oe(dout_oe), .s1_v(s1_v), .s1_wr(s1_wr),
  .s1_addr(s1_addr), .s2_v(s2_v), .s2_wr(s2_wr), .s2_addr(s2_addr),
  .s2_be(s2_be)
);

// File: tb/sim_zt_sram.sv
`timescale 1ns/1ps
module sim_zt_sram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b0, sel = 1'b0, wr = 1'b0, adv = 1'b0, lin_mode = 1'b0, sleep = 1'b0;
  logic [3:0]  lane_we = '0;
  logic [5:0]  addr = '0;
  logic [35:0] din = '0;
  logic [35:0] dout;
  logic        dout_oe;

  zt_sram u0 (.clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel(sel), .wr(wr), .adv(adv),
              .lin_mode(lin_mode), .lane_we(lane_we), .addr(addr), .sleep(sleep),
              .din(din), .dout(dout), .dout_oe(dout_oe));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  string ph = "R2";

  logic [35:0] mm [64];
  logic p1_v = 0, p1_wr = 0, p2_v = 0, p2_wr = 0;
  logic [5:0] p1_a = 0, p2_a = 0;
  logic [3:0] p1_be = 0, p2_be = 0;
  string p1_tag = "R2";
  logic bm_act = 0, bm_wr = 0;
  logic [5:0] bm_base = 0;
  logic [1:0] bm_cnt = 0;
  logic exp_oe = 0;
  logic [35:0] exp_dout = 0;
  string oe_tag = "R5", dat_tag = "R2";

  function automatic logic [35:0] merge(logic [35:0] old, logic [35:0] nw, logic [3:0] be);
    logic [35:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*9 +: 9] = nw[i*9 +: 9];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic ld, st;
    logic [1:0] nc, lo;
    if (!clk_en) begin oe_tag = "R6"; dat_tag = "R6"; return; end
    oe_tag = ph;
    if (p1_v && !p1_wr) begin
      logic [35:0] r = mm[p1_a];
      bit f = p2_v && p2_wr && p2_a == p1_a;
      if (f) r = merge(r, din, p2_be);
      exp_oe = 1; exp_dout = r;
      dat_tag = (f && p2_be != 0) ? "R4" : p1_tag;
    end else exp_oe = 0;
    if (p2_v && p2_wr) mm[p2_a] = merge(mm[p2_a], din, p2_be);
    p2_v = p1_v; p2_wr = p1_wr; p2_a = p1_a; p2_be = p1_be;
    ld = sel && !adv && !sleep;
    st = adv && bm_act && !sleep;
    p1_v = ld || st; p1_be = lane_we;
    if (ld) begin
      p1_wr = wr; p1_a = addr; p1_tag = ph;
      bm_act = 1; bm_wr = wr; bm_base = addr; bm_cnt = 0;
    end else if (st) begin
      nc = bm_cnt + 2'd1;
      lo = lin_mode ? bm_base[1:0] + nc : bm_base[1:0] ^ nc;
      p1_wr = bm_wr; p1_a = {bm_base[5:2], lo}; p1_tag = lin_mode ? "R7" : "R8";
      bm_cnt = nc;
    end else if (!sel && !adv && !sleep) bm_act = 0;
  endtask

  task automatic cyc(input bit ce, input bit s, input bit w, input bit ad, input bit lm,
                     input bit sl, input logic [3:0] be, input logic [5:0] a, input logic [35:0] d);
    clk_en = ce; sel = s; wr = w; adv = ad; lin_mode = lm; sleep = sl;
    lane_we = be; addr = a; din = d;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    chk(dout_oe === exp_oe, oe_tag, {35'd0, dout_oe}, {35'd0, exp_oe});
    if (exp_oe) chk(dout === exp_dout, dat_tag, dout, exp_dout);
  endtask

  function automatic logic [35:0] rnd36();
    return 36'({$urandom(), $urandom()});
  endfunction

  task automatic wrc(input logic [5:0] a, input logic [3:0] be);
    cyc(1, 1, 1, 0, 0, 0, be, a, rnd36());
  endtask
  task automatic rdc(input logic [5:0] a);
    cyc(1, 1, 0, 0, 0, 0, 4'hf, a, rnd36());
  endtask
  task automatic idle();
    cyc(1, 0, 0, 0, 0, 0, 4'hf, 6'd0, rnd36());
  endtask
  task automatic advc(input bit lm, input logic [3:0] be);
    cyc(1, 0, 0, 1, lm, 0, be, 6'd0, rnd36());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0B17));
    for (int i = 0; i < 64; i++) mm[i] = '0;
    repeat (3) begin
      @(negedge clk);
      chk(dout_oe === 1'b0, "R12", {35'd0, dout_oe}, 36'd0);
    end
    rst_n = 1'b1;

    ph = "R2";
    for (int i = 0; i < 64; i++) wrc(6'(i), 4'hf);
    idle(); idle();

    ph = "R1";
    wrc(6'd40, 4'hf); idle(); idle(); rdc(6'd40); idle(); idle();

    ph = "R3";
    wrc(6'd41, 4'hf); rdc(6'd40); wrc(6'd42, 4'hf); rdc(6'd41); rdc(6'd42); wrc(6'd40, 4'h3);
    rdc(6'd40); wrc(6'd43, 4'h5); rdc(6'd43); rdc(6'd43); idle(); idle();

    ph = "R6";
    wrc(6'd44, 4'hf); rdc(6'd44);
    repeat (3) cyc(0, 1, 1, 0, 0, 0, 4'hf, 6'd44, rnd36());
    wrc(6'd44, 4'ha); rdc(6'd44);
    cyc(0, 0, 0, 0, 0, 0, 4'hf, 6'd0, rnd36());
    rdc(6'd44); idle(); idle();

    ph = "R10";
    wrc(6'd45, 4'hf); idle(); wrc(6'd46, 4'h9); idle(); rdc(6'd45); idle(); rdc(6'd46); idle(); idle();

    ph = "R9";
    wrc(6'd47, 4'hf); idle(); advc(1, 4'hf); advc(1, 4'hf); idle(); idle();
    rdc(6'd47); rdc(6'd44); idle(); idle();

    ph = "R11";
    wrc(6'd48, 4'hf);
    cyc(1, 1, 1, 0, 0, 1, 4'hf, 6'd49, rnd36());
    cyc(1, 1, 1, 0, 0, 1, 4'hf, 6'd49, rnd36());
    cyc(1, 0, 0, 1, 1, 1, 4'hf, 6'd0, rnd36());
    idle(); rdc(6'd48); rdc(6'd49); rdc(6'd50); idle(); idle();

    ph = "R7";
    rdc(6'd50); advc(1, 4'hf); advc(1, 4'hf); advc(1, 4'hf); idle(); idle();
    wrc(6'd57, 4'hf); advc(1, 4'h6); advc(1, 4'hf); advc(1, 4'h1);
    rdc(6'd56); rdc(6'd57); rdc(6'd58); rdc(6'd59); idle(); idle();

    ph = "R8";
    rdc(6'd53); advc(0, 4'hf); advc(0, 4'hf); advc(0, 4'hf); idle(); idle();
    rdc(6'd62); advc(0, 4'hf); advc(0, 4'hf); advc(0, 4'hf); advc(0, 4'hf); idle(); idle();

    ph = "R5";
    repeat (6) wrc(6'($urandom_range(32, 63)), 4'($urandom()));
    idle(); idle(); idle();

    ph = "R2";
    for (int n = 0; n < 4000; n++) begin
      bit ce = ($urandom_range(0, 9) != 0);
      bit sl = ($urandom_range(0, 19) == 0);
      bit s  = ($urandom_range(0, 6) != 0);
      bit ad = ($urandom_range(0, 3) == 0);
      cyc(ce, s, 1'($urandom()), ad, 1'($urandom()), sl, 4'($urandom()),
          6'($urandom_range(0, 15)), rnd36());
    end
    idle(); idle(); idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule